// File: doc/BRIEF.md
# Flash Command Interface Controller

This controller sits between a parallel host bus and the array engine of a small NOR-style flash model. The host writes 8-bit command bytes using asynchronous chip-enable, write-enable and output-enable strobes. The controller samples those strobes into its clock domain and decodes each accepted write cycle. From that it selects what a read returns: array data, an identifier word or the status byte.

It also runs the two-cycle program and erase sequences and the erase suspend and resume handshake. It issues one-cycle request pulses to a separate array engine, which reports completion through `eng_done` together with single-bit failure flags. The controller keeps the sticky error bits of the status byte, which only a clear-status command resets.

The central state machine has the states IDLE, ERS_SETUP, PRG_SETUP, PRG_BUSY, ERS_BUSY and SUSPENDED. Its transitions are:
- IDLE to ERS_SETUP on 20h.
- IDLE to PRG_SETUP on 40h or 10h.
- ERS_SETUP to ERS_BUSY on D0h, which also issues the erase start.
- ERS_SETUP to IDLE on any other byte, which is a sequence error.
- PRG_SETUP to PRG_BUSY on the next write cycle, which also issues the program start.
- PRG_BUSY or ERS_BUSY to IDLE on `eng_done`.
- ERS_BUSY to SUSPENDED on B0h.
- SUSPENDED to ERS_BUSY on D0h.

Read modes are encoded as 0 = array, 1 = identifier, 2 = status.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write cycle is accepted only while `bus_oe_n` is high and both `bus_ce_n` and `bus_we_n` are low. A cycle with `bus_oe_n` low changes no mode, state, status or request output.
- R2: One command is latched per cycle, at the first rising edge of either chip-enable or write-enable, whichever strobe rises first. Only `bus_dq[7:0]` forms the command, and the upper data bits and the address do not affect decode.
- R3: After reset, `read_mode` is 0 (array), the controller is idle, status bits 5:3 are zero and status bit 7 is 1.
- R4: Command FFh sets `read_mode` to 0, and `rd_data` then equals `arr_rdata`. Command 70h sets `read_mode` to 2, and `rd_data` then carries the status byte in bits 7:0 with zeros above.
- R5: Command 90h sets `read_mode` to 1. `rd_data` then returns MFR_CODE when `bus_addr[0]` is 0 and DEV_CODE when it is 1.
- R6: Command 50h in IDLE clears status bits 5:3.
- R7: 20h followed directly by D0h gives exactly one `erase_start` pulse. The controller then enters ERS_BUSY, status bit 7 reads 0, and `read_mode` is 2.
- R8: Any of these in IDLE is a sequence error: 00h, B0h, D0h or an unlisted code. So is a byte other than D0h after 20h. A sequence error sets status bits 5 and 4, returns to IDLE and sets `read_mode` to 2.
- R9: 40h or 10h followed by one more write cycle gives exactly one `prog_start` pulse. During that pulse, `prog_addr` and `prog_data` equal that second cycle's address and full data word.
- R10: B0h in ERS_BUSY gives one `suspend_req` pulse and enters SUSPENDED, where status bits 7 and 6 are both 1. All other commands in PRG_BUSY and ERS_BUSY are ignored.
- R11: In SUSPENDED, only FFh, 70h and D0h are acted on. D0h gives one `resume_req` pulse, returns to ERS_BUSY and sets `read_mode` to 2. All other codes are ignored.
- R12: `eng_done` in a busy state returns the controller to IDLE and leaves `read_mode` unchanged. With `eng_fail` it sets bit 4 after a program or bit 5 after an erase, and `vpp_low` sets bit 3.
- R13: Status byte layout: bit 7 means the engine is idle, bit 6 means erase is suspended, bit 5 is the erase error, bit 4 is the program error, bit 3 is the voltage error, and bits 2:0 are 0. Bit 6 is never 1 while bit 7 is 0.
- R14: At most one of `prog_start`, `erase_start`, `suspend_req` and `resume_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Chip enable, active low, asynchronous |
| bus_we_n | input | 1 | Write enable, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable, active low, asynchronous |
| bus_addr | input | ADDR_W | Bus address |
| bus_dq | input | DATA_W | Bus write data |
| arr_rdata | input | DATA_W | Array read data from the storage model |
| eng_done | input | 1 | Array engine finished the current operation |
| eng_fail | input | 1 | Operation failed, valid with eng_done |
| vpp_low | input | 1 | Programming voltage too low, valid with eng_done |
| prog_start | output | 1 | One-cycle program request |
| erase_start | output | 1 | One-cycle erase request |
| suspend_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |
| prog_addr | output | ADDR_W | Program address, valid with prog_start |
| prog_data | output | DATA_W | Program data, valid with prog_start |
| read_mode | output | 2 | 0 array, 1 identifier, 2 status |
| rd_data | output | DATA_W | Read data for the current mode |

## Verification
Some properties are checked by assertions on every cycle:
- The request pulses are mutually exclusive.
- A suspend request always lands in the suspended state.
- The busy flag and the suspend flag never conflict.
- An erase start is always followed by busy.
- A clear or a sequence error leaves the sticky bits in the expected state.
- Completion always restores the ready bit.
- The post-reset mode is array read.

Other behaviour only the bench scenarios can show, by comparing against a reference model:
- The decode of each code in each state.
- The read-back of the identifier words for each address bit.
- The capture of program address and data.
- That ignored commands during busy and suspend leave mode and status unchanged.
- That a cycle with output-enable low or with either strobe order behaves as the rules say.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERS_SETUP,
        ST_PRG_SETUP,
        ST_PRG_BUSY,
        ST_ERS_BUSY,
        ST_SUSPENDED
    } fcc_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_e;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_IDENT      = 8'h90;
    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
    localparam logic [7:0] CMD_ERS_SETUP  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_PRG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_PRG_ALT    = 8'h10;
    localparam logic [7:0] CMD_SUSPEND    = 8'hB0;

endpackage

// File: rtl/fcc_bus_sync.sv
module fcc_bus_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    localparam int NUM_STROBES = 3;

    logic [NUM_STROBES-1:0] raw_strobe;
    logic [NUM_STROBES-1:0] synced;
    logic                   active;
    logic                   active_q;

    assign raw_strobe = {oe_n, we_n, ce_n};

    for (genvar i = 0; i < NUM_STROBES; i++) begin : g_strobe
        logic [SYNC_STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[SYNC_STAGES-2:0], raw_strobe[i]};
            end
        end
        assign synced[i] = chain_q[SYNC_STAGES-1];
    end

    // write cycle: output enable high, chip and write enable low
    assign active   = synced[2] & ~synced[1] & ~synced[0];
    // first strobe to rise ends the cycle; the second finds it already ended
    assign wr_pulse = active_q & ~active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            active_q <= active;
            if (active) begin
                cap_addr <= addr;
                cap_data <= dq;
            end
        end
    end

endmodule

// File: rtl/fcc_cmd_fsm.sv
module fcc_cmd_fsm
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              eng_done,
    input  logic              eng_fail,
    input  logic              vpp_low,
    output rd_mode_e          read_mode,
    output logic              ready,
    output logic              suspended,
    output logic              prog_start,
    output logic              erase_start,
    output logic              suspend_req,
    output logic              resume_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              seq_err,
    output logic              prg_fail_set,
    output logic              ers_fail_set,
    output logic              vpp_set,
    output logic              clr_stat
);

    fcc_state_e state, nxt_state;
    rd_mode_e   nxt_mode;
    logic [7:0] cmd;

    assign cmd       = cap_data[7:0];
    assign prog_addr = cap_addr;
    assign prog_data = cap_data;
    assign ready     = (state != ST_PRG_BUSY) && (state != ST_ERS_BUSY);
    assign suspended = (state == ST_SUSPENDED);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            read_mode <= RM_ARRAY;
        end else begin
            state     <= nxt_state;
            read_mode <= nxt_mode;
        end
    end

    // transitions and outputs
    always_comb begin
        nxt_state    = state;
        nxt_mode     = read_mode;
        prog_start   = 1'b0;
        erase_start  = 1'b0;
        suspend_req  = 1'b0;
        resume_req   = 1'b0;
        seq_err      = 1'b0;
        prg_fail_set = 1'b0;
        ers_fail_set = 1'b0;
        vpp_set      = 1'b0;
        clr_stat     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_pulse) begin
                    case (cmd)
                        CMD_READ_ARRAY: nxt_mode = RM_ARRAY;
                        CMD_IDENT:      nxt_mode = RM_IDENT;
                        CMD_READ_STAT:  nxt_mode = RM_STATUS;
                        CMD_CLR_STAT:   clr_stat = 1'b1;
                        CMD_ERS_SETUP: begin
                            nxt_state = ST_ERS_SETUP;
                            nxt_mode  = RM_STATUS;
                        end
                        CMD_PRG_SETUP, CMD_PRG_ALT: begin
                            nxt_state = ST_PRG_SETUP;
                            nxt_mode  = RM_STATUS;
                        end
                        default: begin
                            seq_err  = 1'b1;
                            nxt_mode = RM_STATUS;
                        end
                    endcase
                end
            end
            ST_ERS_SETUP: begin
                if (wr_pulse) begin
                    if (cmd == CMD_CONFIRM) begin
                        erase_start = 1'b1;
                        nxt_state   = ST_ERS_BUSY;
                    end else begin
                        seq_err   = 1'b1;
                        nxt_state = ST_IDLE;
                    end
                    nxt_mode = RM_STATUS;
                end
            end
            ST_PRG_SETUP: begin
                if (wr_pulse) begin
                    prog_start = 1'b1;
                    nxt_state  = ST_PRG_BUSY;
                end
            end
            ST_PRG_BUSY: begin
                if (eng_done) begin
                    nxt_state    = ST_IDLE;
                    prg_fail_set = eng_fail;
                    vpp_set      = vpp_low;
                end
            end
            ST_ERS_BUSY: begin
                if (eng_done) begin
                    nxt_state    = ST_IDLE;
                    ers_fail_set = eng_fail;
                    vpp_set      = vpp_low;
                end else if (wr_pulse && cmd == CMD_SUSPEND) begin
                    suspend_req = 1'b1;
                    nxt_state   = ST_SUSPENDED;
                end
            end
            ST_SUSPENDED: begin
                if (wr_pulse) begin
                    case (cmd)
                        CMD_READ_ARRAY: nxt_mode = RM_ARRAY;
                        CMD_READ_STAT:  nxt_mode = RM_STATUS;
                        CMD_CONFIRM: begin
                            resume_req = 1'b1;
                            nxt_state  = ST_ERS_BUSY;
                            nxt_mode   = RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // R14
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({prog_start, erase_start, suspend_req, resume_req}) <= 1);

    // R10
    susp_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |=> suspended && ready);

    // R13
    busy_not_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !suspended);

    // R7
    erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !ready && read_mode == RM_STATUS);

    // R12
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !ready) |=> ready && $stable(read_mode));

    // R3
    reset_mode_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (read_mode == RM_ARRAY) && ready);

endmodule

// File: rtl/fcc_status_reg.sv
module fcc_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready,
    input  logic       suspended,
    input  logic       seq_err,
    input  logic       prg_fail_set,
    input  logic       ers_fail_set,
    input  logic       vpp_set,
    input  logic       clr_stat,
    output logic [7:0] status_byte
);

    // sticky flags: [2] erase error, [1] program error, [0] voltage error
    logic [2:0] err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (clr_stat) begin
            err_q <= '0;
        end else begin
            err_q <= err_q | {seq_err | ers_fail_set, seq_err | prg_fail_set, vpp_set};
        end
    end

    assign status_byte = {ready, suspended, err_q, 3'b000};

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stat |=> status_byte[5:3] == 3'b000);

    // R8
    seq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> status_byte[5:4] == 2'b11);

endmodule

// File: rtl/fcc_read_mux.sv
module fcc_read_mux
    import fcc_pkg::*;
#(
    parameter int              DATA_W   = 16,
    parameter logic [DATA_W-1:0] MFR_CODE = '0,
    parameter logic [DATA_W-1:0] DEV_CODE = '0
) (
    input  rd_mode_e          read_mode,
    input  logic              addr_lsb,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [7:0]        status_byte,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        rd_data = '0;
        unique case (read_mode)
            RM_ARRAY:  rd_data = arr_rdata;
            RM_IDENT:  rd_data = addr_lsb ? DEV_CODE : MFR_CODE;
            RM_STATUS: rd_data = {{(DATA_W-8){1'b0}}, status_byte};
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int              ADDR_W      = 18,
    parameter int              DATA_W      = 16,
    parameter int              SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] MFR_CODE  = 16'h00A7,
    parameter logic [DATA_W-1:0] DEV_CODE  = 16'h0C3E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_dq,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              eng_done,
    input  logic              eng_fail,
    input  logic              vpp_low,
    output logic              prog_start,
    output logic              erase_start,
    output logic              suspend_req,
    output logic              resume_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic [1:0]        read_mode,
    output logic [DATA_W-1:0] rd_data
);

    logic              wr_pulse;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    rd_mode_e          mode;
    logic              ready, suspended;
    logic              seq_err, prg_fail_set, ers_fail_set, vpp_set, clr_stat;
    logic [7:0]        status_byte;

    fcc_bus_sync #(
        .SYNC_STAGES(SYNC_STAGES),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (bus_ce_n),
        .we_n    (bus_we_n),
        .oe_n    (bus_oe_n),
        .addr    (bus_addr),
        .dq      (bus_dq),
        .wr_pulse(wr_pulse),
        .cap_addr(cap_addr),
        .cap_data(cap_data)
    );

    fcc_cmd_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_pulse    (wr_pulse),
        .cap_addr    (cap_addr),
        .cap_data    (cap_data),
        .eng_done    (eng_done),
        .eng_fail    (eng_fail),
        .vpp_low     (vpp_low),
        .read_mode   (mode),
        .ready       (ready),
        .suspended   (suspended),
        .prog_start  (prog_start),
        .erase_start (erase_start),
        .suspend_req (suspend_req),
        .resume_req  (resume_req),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .seq_err     (seq_err),
        .prg_fail_set(prg_fail_set),
        .ers_fail_set(ers_fail_set),
        .vpp_set     (vpp_set),
        .clr_stat    (clr_stat)
    );

    fcc_status_reg status_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready       (ready),
        .suspended   (suspended),
        .seq_err     (seq_err),
        .prg_fail_set(prg_fail_set),
        .ers_fail_set(ers_fail_set),
        .vpp_set     (vpp_set),
        .clr_stat    (clr_stat),
        .status_byte (status_byte)
    );

    fcc_read_mux #(
        .DATA_W  (DATA_W),
        .MFR_CODE(MFR_CODE),
        .DEV_CODE(DEV_CODE)
    ) rmux_i (
        .read_mode  (mode),
        .addr_lsb   (bus_addr[0]),
        .arr_rdata  (arr_rdata),
        .status_byte(status_byte),
        .rd_data    (rd_data)
    );

    assign read_mode = mode;

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] MFR = 16'h00A7;
    localparam logic [15:0] DEV = 16'h0C3E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
    logic [17:0] bus_addr = '0;
    logic [15:0] bus_dq = '0;
    logic [15:0] arr_rdata = '0;
    logic        eng_done = 1'b0, eng_fail = 1'b0, vpp_low = 1'b0;
    logic        prog_start, erase_start, suspend_req, resume_req;
    logic [17:0] prog_addr;
    logic [15:0] prog_data;
    logic [1:0]  read_mode;
    logic [15:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
        .bus_addr(bus_addr), .bus_dq(bus_dq), .arr_rdata(arr_rdata),
        .eng_done(eng_done), .eng_fail(eng_fail), .vpp_low(vpp_low),
        .prog_start(prog_start), .erase_start(erase_start),
        .suspend_req(suspend_req), .resume_req(resume_req),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .read_mode(read_mode), .rd_data(rd_data)
    );

    int n_checks = 0, n_errors = 0;
    bit finished = 0;

    // observed request pulses
    int          obs_prog = 0, obs_erase = 0, obs_susp = 0, obs_res = 0;
    logic [17:0] obs_paddr = '0;
    logic [15:0] obs_pdata = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prog_start) begin
                obs_prog++;
                obs_paddr = prog_addr;
                obs_pdata = prog_data;
            end
            if (erase_start) obs_erase++;
            if (suspend_req) obs_susp++;
            if (resume_req)  obs_res++;
        end
    end

    // reference model: 0 idle,1 erase setup,2 prog setup,3 prog busy,4 erase busy,5 suspended
    int          m_state = 0;
    logic [1:0]  m_mode = 2'd0;
    logic [2:0]  m_err = 3'b000;   // [2] bit5 erase, [1] bit4 program, [0] bit3 voltage
    int          e_prog = 0, e_erase = 0, e_susp = 0, e_res = 0;
    logic [17:0] e_paddr = '0;
    logic [15:0] e_pdata = '0;

    function automatic logic [7:0] exp_status();
        return {(m_state != 3 && m_state != 4), (m_state == 5), m_err, 3'b000};
    endfunction

    function automatic logic [15:0] exp_read(input logic a0, input logic [15:0] arr);
        case (m_mode)
            2'd0:    return arr;
            2'd1:    return a0 ? DEV : MFR;
            default: return {8'h00, exp_status()};
        endcase
    endfunction

    task automatic model_cmd(input logic [15:0] d, input logic [17:0] a);
        logic [7:0] c;
        c = d[7:0];
        case (m_state)
            0: begin
                case (c)
                    8'hFF: m_mode = 2'd0;
                    8'h90: m_mode = 2'd1;
                    8'h70: m_mode = 2'd2;
                    8'h50: m_err = 3'b000;
                    8'h20: begin m_state = 1; m_mode = 2'd2; end
                    8'h40, 8'h10: begin m_state = 2; m_mode = 2'd2; end
                    default: begin m_err = m_err | 3'b110; m_mode = 2'd2; end
                endcase
            end
            1: begin
                if (c == 8'hD0) begin m_state = 4; e_erase++; end
                else begin m_err = m_err | 3'b110; m_state = 0; end
                m_mode = 2'd2;
            end
            2: begin m_state = 3; e_prog++; e_paddr = a; e_pdata = d; end
            3: ;
            4: if (c == 8'hB0) begin m_state = 5; e_susp++; end
            5: begin
                case (c)
                    8'hFF: m_mode = 2'd0;
                    8'h70: m_mode = 2'd2;
                    8'hD0: begin m_state = 4; e_res++; m_mode = 2'd2; end
                    default: ;
                endcase
            end
            default: ;
        endcase
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [17:0] a, input logic [15:0] d, input bit oe_hi, input bit ce_first);
        @(negedge clk);
        bus_addr = a; bus_dq = d;
        bus_oe_n = oe_hi; bus_ce_n = 1'b0; bus_we_n = 1'b0;
        repeat (4) @(negedge clk);
        if (ce_first) bus_ce_n = 1'b1; else bus_we_n = 1'b1;
        @(negedge clk);
        bus_ce_n = 1'b1; bus_we_n = 1'b1; bus_oe_n = 1'b1;
        repeat (6) @(negedge clk);
        if (oe_hi) model_cmd(d, a);
    endtask

    task automatic check_all(input string tag);
        logic a0;
        logic [15:0] arr;
        a0 = 1'($urandom);
        arr = 16'($urandom);
        @(negedge clk);
        bus_addr[0] = a0;
        arr_rdata = arr;
        #1;
        chk(read_mode == m_mode, {tag, " read_mode"}, 32'(read_mode), 32'(m_mode));
        chk(rd_data == exp_read(a0, arr), {tag, " rd_data"}, 32'(rd_data), 32'(exp_read(a0, arr)));
        chk(obs_prog == e_prog && obs_erase == e_erase && obs_susp == e_susp && obs_res == e_res,
            {tag, " R14 request counts"},
            32'({8'(obs_prog), 8'(obs_erase), 8'(obs_susp), 8'(obs_res)}),
            32'({8'(e_prog), 8'(e_erase), 8'(e_susp), 8'(e_res)}));
        if (e_prog > 0)
            chk(obs_paddr == e_paddr && obs_pdata == e_pdata, {tag, " R9 program word"},
                32'({obs_paddr[15:0], obs_pdata}), 32'({e_paddr[15:0], e_pdata}));
    endtask

    task automatic cmd(input logic [7:0] c, input string tag);
        bus_cycle(18'($urandom), {8'($urandom), c}, 1'b1, 1'($urandom));
        check_all(tag);
    endtask

    task automatic engine_done(input bit fail, input bit vlow, input string tag);
        @(negedge clk);
        eng_done = 1'b1; eng_fail = fail; vpp_low = vlow;
        @(negedge clk);
        eng_done = 1'b0; eng_fail = 1'b0; vpp_low = 1'b0;
        if (m_state == 3) begin
            m_state = 0;
            if (fail) m_err[1] = 1'b1;
            if (vlow) m_err[0] = 1'b1;
        end else if (m_state == 4) begin
            m_state = 0;
            if (fail) m_err[2] = 1'b1;
            if (vlow) m_err[0] = 1'b1;
        end
        repeat (2) @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] codes [12];
        codes = '{8'hFF, 8'h90, 8'h70, 8'h50, 8'h20, 8'hD0, 8'h40, 8'h10, 8'hB0, 8'h00, 8'h20, 8'hD0};
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 reset state
        check_all("R3 reset");
        cmd(8'h70, "R3 R13 R4 status after reset");

        // R1 cycle with output enable low ignored
        bus_cycle(18'h1, 16'h0090, 1'b0, 1'b1);
        check_all("R1 oe low ignored");

        // R5 identifier, both strobe orders (R2), junk upper byte
        bus_cycle(18'h0, 16'hA590, 1'b1, 1'b0);
        check_all("R5 R2 ident via we first");
        check_all("R5 ident second address");
        cmd(8'hFF, "R4 array mode");
        bus_cycle(18'h3, 16'h5A90, 1'b1, 1'b1);
        check_all("R2 ce first ident");

        // R8 erase setup then wrong byte, R6 clear
        cmd(8'h20, "R8 erase setup");
        cmd(8'hFF, "R8 setup not confirmed");
        cmd(8'h00, "R8 invalid code");
        cmd(8'h50, "R6 clear status");

        // R9 program
        cmd(8'h40, "R9 program setup");
        bus_cycle(18'h2ABCD, 16'hBEEF, 1'b1, 1'b0);
        check_all("R9 program data cycle");
        cmd(8'h90, "R10 ignored while program busy");
        engine_done(1'b1, 1'b0, "R12 program fail");
        cmd(8'h10, "R9 alternate setup");
        bus_cycle(18'h00013, 16'h1234, 1'b1, 1'b1);
        check_all("R9 second program");
        engine_done(1'b0, 1'b1, "R12 voltage flag");
        cmd(8'h50, "R6 clear after errors");

        // R7 R10 R11 erase with suspend and resume
        cmd(8'h20, "R7 erase setup");
        cmd(8'hD0, "R7 erase confirm");
        cmd(8'hFF, "R10 ignored while erase busy");
        cmd(8'hB0, "R10 suspend");
        cmd(8'h90, "R11 ident refused in suspend");
        cmd(8'h50, "R11 clear refused in suspend");
        cmd(8'hFF, "R11 array read in suspend");
        cmd(8'h70, "R11 status read in suspend");
        cmd(8'hD0, "R11 resume");
        engine_done(1'b1, 1'b0, "R12 erase fail");
        cmd(8'h37, "R8 unlisted code");
        cmd(8'hD0, "R8 confirm without setup");
        cmd(8'h50, "R6 clear");

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [7:0] c;
            c = (($urandom % 8) == 0) ? 8'($urandom) : codes[$urandom % 12];
            if (m_state == 2) begin
                bus_cycle(18'($urandom), 16'($urandom), 1'b1, 1'($urandom));
                check_all("R9 random program");
            end else if ((m_state == 3 || m_state == 4) && ($urandom % 3 == 0)) begin
                engine_done(1'($urandom), 1'($urandom), "R12 random done");
            end else if ($urandom % 10 == 0) begin
                bus_cycle(18'($urandom), {8'($urandom), c}, 1'b0, 1'($urandom));
                check_all("R1 random oe low");
            end else begin
                cmd(c, "R13 random command");
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule